// File: doc/BRIEF.md
# Power Domain Switch Controller

This block lets software switch up to 64 power domains on and off through a 32-bit register port. Each domain has its own small window with a state register, a switch-on command, a switch-off command and an error flag. A global ready field says whether the controller can take a new request. Only one switching sequence runs at a time. A request that arrives while a sequence runs is refused: the domain's error flag is set and software must submit it again. The switching itself is modelled as a fixed number of cycles per accepted request.

When a sequence finishes, the domain's completion flag is set, but only if its enable bit is set. Completion flags are cleared by writing 1. A mask bit keeps a flag away from the interrupt line. This lets software enable a flag, mask it, and poll it without taking an interrupt. The domain flags are grouped in two 32-bit banks. Domain d sits in bank d/32 at bit d%32.

Reads are combinational from `addr_i`. Writes take effect at the rising clock edge where `req_i` and `we_i` are high.

Top module: `pwr_dom_ctrl`

## Requirements
- R1: The global status register at 0x000 reads 3 in bits [1:0] when idle. It reads 0 from the edge that accepts a request until SEQ_CYCLES rising edges later, so busy lasts exactly SEQ_CYCLES cycles.
- R2: Domain d's window starts at 0x1000 + d*0x40. Writing a value with bit 0 set to +0x4 requests power-on, and to +0x8 requests power-off. A command write with bit 0 clear does nothing.
- R3: The state register at window offset +0x0 has four bits. Bit 0 is set while the domain is off, and bit 4 while it is on. Bit 12 is set while a power-on sequence runs for that domain, and bit 8 while a power-off sequence runs.
- R4: A request made while any sequence runs starts nothing and sets bit 0 of that domain's error register at +0xC. An accepted request clears that bit.
- R5: At the end of a sequence the domain takes the requested state. The power-on status banks at 0x800/0x804 show one bit per domain that is on. The power-off banks at 0x808/0x80C show one bit per valid domain that is off.
- R6: A completion flag in the banks at 0x810/0x814 is set at the end of a sequence only if the domain's enable bit (0x820/0x824) is set. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R7: `irq_o` is high exactly when some completion flag is set and its mask bit (0x830/0x834) is clear.
- R8: For domains at or above NUM_DOM, everything reads zero and writes are ignored. This covers window reads, command writes and enable/mask bits.
- R9: After reset every domain is off, and all error, completion, enable and mask bits are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 13 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Completion interrupt |

## Verification
Every valid domain is powered on in turn. During each sequence, a request to the next domain is refused and later resubmitted, which separates the busy window, the refusal, the error clear and the exact last busy cycle. Enable bits are set only on even domains, which separates recorded completions from silent ones. A power-off, an unmasked versus masked flag, commands with bit 0 clear, and accesses to domains above the configured count cover the remaining decode and irq behaviour.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int unsigned MAX_DOM = 64;
  localparam int unsigned BANK_W  = 32;
  localparam int unsigned N_BANK  = MAX_DOM / BANK_W;
  localparam int unsigned DOM_W   = $clog2(MAX_DOM);
  localparam int unsigned ADDR_W  = 13;

  typedef enum logic [3:0] {
    RK_NONE, RK_GSTAT, RK_ONSTAT, RK_OFFSTAT, RK_ISR, RK_IER, RK_IMR,
    RK_DSTATE, RK_DON, RK_DOFF, RK_DERR
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    logic             bank;
    logic [DOM_W-1:0] dom;
  } reg_sel_t;

  function automatic logic [MAX_DOM-1:0] dom_mask(int unsigned n);
    logic [MAX_DOM-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_DOM; i++) if (i < int'(n)) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pdc_addr_dec.sv
module pdc_addr_dec import pdc_pkg::*; #(
  parameter int unsigned NUM_DOM = 40
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_t          sel_o
);
  logic [DOM_W-1:0] dom;
  logic             dom_ok;

  assign dom    = addr_i[11:6];
  assign dom_ok = {{(32-DOM_W){1'b0}}, dom} < NUM_DOM;

  always_comb begin
    sel_o.kind = RK_NONE;
    sel_o.bank = addr_i[2];
    sel_o.dom  = dom;
    if (addr_i[12]) begin
      if (dom_ok && addr_i[5:4] == 2'b00 && addr_i[1:0] == 2'b00) begin
        unique case (addr_i[3:2])
          2'd0: sel_o.kind = RK_DSTATE;
          2'd1: sel_o.kind = RK_DON;
          2'd2: sel_o.kind = RK_DOFF;
          default: sel_o.kind = RK_DERR;
        endcase
      end
    end else if (addr_i[11:0] == 12'h000) begin
      sel_o.kind = RK_GSTAT;
    end else if (addr_i[11:8] == 4'h8 && addr_i[1:0] == 2'b00) begin
      unique case (addr_i[7:4])
        4'h0: sel_o.kind = addr_i[3] ? RK_OFFSTAT : RK_ONSTAT;
        4'h1: sel_o.kind = addr_i[3] ? RK_NONE : RK_ISR;
        4'h2: sel_o.kind = addr_i[3] ? RK_NONE : RK_IER;
        4'h3: sel_o.kind = addr_i[3] ? RK_NONE : RK_IMR;
        default: sel_o.kind = RK_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pdc_seq.sv
module pdc_seq import pdc_pkg::*; #(
  parameter int unsigned SEQ_CYCLES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [DOM_W-1:0]   req_dom_i,
  input  logic               req_on_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [DOM_W-1:0]   cur_dom_o,
  output logic               cur_on_o,
  output logic [MAX_DOM-1:0] pwr_on_o,
  output logic [MAX_DOM-1:0] err_o
);
  localparam int unsigned CNT_W = $clog2(SEQ_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SEQ_CYCLES - 1);

  logic               busy_q, on_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [DOM_W-1:0]   dom_q;
  logic [MAX_DOM-1:0] pwr_q, err_q;

  assign done_o = busy_q && cnt_q == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      on_q   <= 1'b0;
      cnt_q  <= '0;
      dom_q  <= '0;
      pwr_q  <= '0;
      err_q  <= '0;
    end else begin
      if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q       <= 1'b0;
          pwr_q[dom_q] <= on_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      // requests meeting the last busy cycle are still refused
      if (req_i) begin
        if (busy_q) begin
          err_q[req_dom_i] <= 1'b1;
        end else begin
          err_q[req_dom_i] <= 1'b0;
          busy_q           <= 1'b1;
          cnt_q            <= CNT_LOAD;
          dom_q            <= req_dom_i;
          on_q             <= req_on_i;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign cur_dom_o = dom_q;
  assign cur_on_o  = on_q;
  assign pwr_on_o  = pwr_q;
  assign err_o     = err_q;
endmodule

// File: rtl/pdc_irq_bank.sv
module pdc_irq_bank import pdc_pkg::*; #(
  parameter int unsigned NUM_DOM = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_isr_i,
  input  logic               wr_ier_i,
  input  logic               wr_imr_i,
  input  logic               bank_i,
  input  logic [BANK_W-1:0]  wdata_i,
  input  logic               done_i,
  input  logic [DOM_W-1:0]   done_dom_i,
  output logic [MAX_DOM-1:0] isr_o,
  output logic [MAX_DOM-1:0] ier_o,
  output logic [MAX_DOM-1:0] imr_o,
  output logic               irq_o
);
  localparam logic [MAX_DOM-1:0] VALID = dom_mask(NUM_DOM);

  logic [MAX_DOM-1:0] isr_q, ier_q, imr_q, isr_d, ier_d, imr_d;

  always_comb begin
    isr_d = isr_q;
    ier_d = ier_q;
    imr_d = imr_q;
    for (int b = 0; b < N_BANK; b++) begin
      if (bank_i == b[0]) begin
        if (wr_ier_i) ier_d[b*BANK_W +: BANK_W] = wdata_i;
        if (wr_imr_i) imr_d[b*BANK_W +: BANK_W] = wdata_i;
        if (wr_isr_i) isr_d[b*BANK_W +: BANK_W] = isr_q[b*BANK_W +: BANK_W] & ~wdata_i;
      end
    end
    // completion wins over a same-cycle clear
    if (done_i && ier_q[done_dom_i]) isr_d[done_dom_i] = 1'b1;
    isr_d &= VALID;
    ier_d &= VALID;
    imr_d &= VALID;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
      ier_q <= '0;
      imr_q <= '0;
    end else begin
      isr_q <= isr_d;
      ier_q <= ier_d;
      imr_q <= imr_d;
    end
  end

  assign isr_o = isr_q;
  assign ier_o = ier_q;
  assign imr_o = imr_q;
  assign irq_o = |(isr_q & ~imr_q);
endmodule

// File: rtl/pwr_dom_ctrl.sv
module pwr_dom_ctrl import pdc_pkg::*; #(
  parameter int unsigned NUM_DOM    = 40,
  parameter int unsigned SEQ_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam logic [MAX_DOM-1:0] VALID = dom_mask(NUM_DOM);

  reg_sel_t           sel;
  logic               wr, cmd_req, cmd_on;
  logic               seq_busy, seq_done, seq_on;
  logic [DOM_W-1:0]   seq_dom;
  logic [MAX_DOM-1:0] pwr_on, err, isr, ier, imr;

  pdc_addr_dec #(.NUM_DOM(NUM_DOM)) i_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign wr      = req_i && we_i;
  assign cmd_on  = sel.kind == RK_DON;
  assign cmd_req = wr && wdata_i[0] && (cmd_on || sel.kind == RK_DOFF);

  pdc_seq #(.SEQ_CYCLES(SEQ_CYCLES)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (cmd_req),
    .req_dom_i (sel.dom),
    .req_on_i  (cmd_on),
    .busy_o    (seq_busy),
    .done_o    (seq_done),
    .cur_dom_o (seq_dom),
    .cur_on_o  (seq_on),
    .pwr_on_o  (pwr_on),
    .err_o     (err)
  );

  pdc_irq_bank #(.NUM_DOM(NUM_DOM)) i_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_isr_i   (wr && sel.kind == RK_ISR),
    .wr_ier_i   (wr && sel.kind == RK_IER),
    .wr_imr_i   (wr && sel.kind == RK_IMR),
    .bank_i     (sel.bank),
    .wdata_i    (wdata_i),
    .done_i     (seq_done),
    .done_dom_i (seq_dom),
    .isr_o      (isr),
    .ier_o      (ier),
    .imr_o      (imr),
    .irq_o      (irq_o)
  );

  function automatic logic [BANK_W-1:0] pick(logic [MAX_DOM-1:0] v, logic b);
    return b ? v[2*BANK_W-1:BANK_W] : v[BANK_W-1:0];
  endfunction

  logic here;
  assign here = seq_busy && seq_dom == sel.dom;

  always_comb begin
    rdata_o = '0;
    unique case (sel.kind)
      RK_GSTAT:   rdata_o[1:0] = seq_busy ? 2'b00 : 2'b11;
      RK_ONSTAT:  rdata_o = pick(pwr_on, sel.bank);
      RK_OFFSTAT: rdata_o = pick(~pwr_on & VALID, sel.bank);
      RK_ISR:     rdata_o = pick(isr, sel.bank);
      RK_IER:     rdata_o = pick(ier, sel.bank);
      RK_IMR:     rdata_o = pick(imr, sel.bank);
      RK_DSTATE: begin
        rdata_o[0]  = ~pwr_on[sel.dom];
        rdata_o[4]  = pwr_on[sel.dom];
        rdata_o[8]  = here && !seq_on;
        rdata_o[12] = here && seq_on;
      end
      RK_DERR:    rdata_o[0] = err[sel.dom];
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pdc_chk.sv
module pdc_chk import pdc_pkg::*; #(
  parameter int unsigned NUM_DOM    = 40,
  parameter int unsigned SEQ_CYCLES = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               busy_i,
  input logic               done_i,
  input logic               irq_i,
  input logic [MAX_DOM-1:0] pwr_on_i,
  input logic [MAX_DOM-1:0] isr_i,
  input logic [MAX_DOM-1:0] ier_i,
  input logic [MAX_DOM-1:0] imr_i
);
  localparam logic [MAX_DOM-1:0] VALID = dom_mask(NUM_DOM);

  int unsigned run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 0;
    else         run_q <= busy_i ? run_q + 1 : 0;
  end

  // R1
  seq_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) run_q <= SEQ_CYCLES);
  // R1
  seq_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) done_i |=> !busy_i);
  // R4
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) (busy_i && !done_i) |=> busy_i);
  // R5
  pwr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !busy_i |=> $stable(pwr_on_i));
  // R6
  flag_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((isr_i & ~$past(isr_i) & ~$past(ier_i)) == '0));
  // R7
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_i |-> (isr_i != '0));
  // R8
  range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pwr_on_i | isr_i | ier_i | imr_i) & ~VALID) == '0);
endmodule

bind pwr_dom_ctrl pdc_chk #(.NUM_DOM(NUM_DOM), .SEQ_CYCLES(SEQ_CYCLES)) i_pdc_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_i   (seq_busy),
  .done_i   (seq_done),
  .irq_i    (irq_o),
  .pwr_on_i (pwr_on),
  .isr_i    (isr),
  .ier_i    (ier),
  .imr_i    (imr)
);

// File: tb/test_pwr_dom_ctrl.sv
module test_pwr_dom_ctrl;
  localparam int NUM = 40;
  localparam int SEQ = 6;
  localparam logic [63:0] VALID = (64'd1 << NUM) - 64'd1;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [12:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [63:0] m_on = '0, m_err = '0, m_isr = '0, m_ier = '0, m_imr = '0;

  always #5 clk = ~clk;

  pwr_dom_ctrl #(.NUM_DOM(NUM), .SEQ_CYCLES(SEQ)) i_pwr_dom_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [12:0] wa(int d, int off);
    return 13'(32'h1000 + d * 64 + off);
  endfunction

  function automatic logic [12:0] ba(int grp, int b);
    return 13'(32'h800 + grp + b * 4);
  endfunction

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rdc(input logic [12:0] a, input logic [31:0] exp, input string r);
    addr = a; req = 1'b1; we = 1'b0;
    #1;
    chk(r, rdata, exp);
    req = 1'b0;
  endtask

  task automatic accept(input int d, input bit on);
    m_on[d] = on;
    m_err[d] = 1'b0;
    if (m_ier[d]) m_isr[d] = 1'b1;
  endtask

  task automatic run(input int d, input bit on);
    wr(wa(d, on ? 4 : 8), 32'h1);
    repeat (SEQ) @(negedge clk);
    accept(d, on);
  endtask

  task automatic chk_banks(input string r);
    for (int b = 0; b < 2; b++) begin
      rdc(ba(8'h00, b), m_on[b*32 +: 32], r);
      rdc(ba(8'h08, b), (~m_on & VALID) >> (b * 32), r);
      rdc(ba(8'h10, b), m_isr[b*32 +: 32], r);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9 reset state
    rdc(13'h000, 32'h3, "R9 gstat");
    for (int d = 0; d < NUM; d++) begin
      rdc(wa(d, 0), 32'h1, "R9 state off");
      rdc(wa(d, 12), 32'h0, "R9 err clear");
    end
    chk_banks("R9 banks");
    for (int b = 0; b < 2; b++) begin
      rdc(ba(8'h20, b), 32'h0, "R9 ier");
      rdc(ba(8'h30, b), 32'h0, "R9 imr");
    end
    chk("R9 irq", {31'd0, irq}, 32'd0);

    // R6 enable even domains only
    m_ier = 64'h5555_5555_5555_5555 & VALID;
    wr(ba(8'h20, 0), m_ier[31:0]);
    wr(ba(8'h20, 1), 32'h5555_5555);
    rdc(ba(8'h20, 1), m_ier[63:32], "R8 ier masked");

    // R2 R3 R1 R4 R5 R6: sweep power-on over all domains
    for (int d = 0; d < NUM; d++) begin
      int o;
      o = (d + 1) % NUM;
      wr(wa(d, 4), 32'h1);
      rdc(wa(d, 0), m_on[d] ? 32'h1010 : 32'h1001, "R3 on in progress");
      wr(wa(o, 8), 32'h1);
      m_err[o] = 1'b1;
      rdc(wa(o, 12), 32'h1, "R4 refused sets err");
      rdc(13'h000, 32'h0, "R1 busy");
      rdc(wa(o, 0), m_on[o] ? 32'h10 : 32'h1, "R4 refused starts nothing");
      repeat (SEQ - 3) @(negedge clk);
      rdc(13'h000, 32'h0, "R1 last busy cycle");
      @(negedge clk);
      accept(d, 1'b1);
      rdc(13'h000, 32'h3, "R1 ready after sequence");
      rdc(wa(d, 0), 32'h10, "R3 R5 on");
      rdc(wa(d, 12), 32'h0, "R4 accepted clears err");
      chk_banks("R5 R6 banks");
      chk("R7 irq unmasked", {31'd0, irq}, {31'd0, |(m_isr & ~m_imr)});
      // R4 resubmit
      run(o, 1'b0);
      rdc(wa(o, 12), 32'h0, "R4 retry accepted");
      wr(ba(8'h10, 0), m_isr[31:0]);
      wr(ba(8'h10, 1), m_isr[63:32]);
      m_isr = '0;
      chk_banks("R6 w1c");
    end

    // R2 command with bit 0 clear
    wr(wa(5, 8), 32'hFFFF_FFFE);
    rdc(13'h000, 32'h3, "R2 bit0 clear no request");
    rdc(wa(5, 0), m_on[5] ? 32'h10 : 32'h1, "R2 state unchanged");

    // R3 R5 power-off with bit 8
    m_on[3] = 1'b1;
    run(3, 1'b1);
    wr(wa(3, 8), 32'h1);
    rdc(wa(3, 0), 32'h0110, "R3 off in progress");
    repeat (SEQ) @(negedge clk);
    accept(3, 1'b0);
    rdc(wa(3, 0), 32'h1, "R3 R5 off");
    chk_banks("R5 off banks");

    // R7 mask behaviour
    wr(ba(8'h10, 0), 32'hFFFF_FFFF);
    wr(ba(8'h10, 1), 32'hFFFF_FFFF);
    m_isr = '0;
    m_ier[3] = 1'b1;
    m_imr[3] = 1'b1;
    wr(ba(8'h20, 0), m_ier[31:0]);
    wr(ba(8'h30, 0), m_imr[31:0]);
    run(3, 1'b1);
    rdc(ba(8'h10, 0), 32'h8, "R6 masked flag recorded");
    chk("R7 masked no irq", {31'd0, irq}, 32'd0);
    wr(ba(8'h30, 0), 32'h0);
    #1 chk("R7 unmasked irq", {31'd0, irq}, 32'd1);
    wr(ba(8'h10, 0), 32'h20);
    #1 chk("R6 w1c other bit keeps irq", {31'd0, irq}, 32'd1);
    wr(ba(8'h10, 0), 32'h8);
    #1 chk("R6 R7 cleared", {31'd0, irq}, 32'd0);
    rdc(ba(8'h10, 0), 32'h0, "R6 flag cleared");

    // R8 domains above NUM_DOM
    wr(wa(45, 4), 32'h1);
    rdc(13'h000, 32'h3, "R8 no sequence for dom 45");
    rdc(wa(45, 0), 32'h0, "R8 state reads zero");
    rdc(wa(63, 12), 32'h0, "R8 err reads zero");
    wr(ba(8'h30, 1), 32'hFFFF_FFFF);
    rdc(ba(8'h30, 1), 32'h0000_00FF, "R8 imr masked");
    rdc(ba(8'h08, 1), (~m_on & VALID) >> 32, "R8 off bank masked");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule